// File: doc/BRIEF.md
# Bus Slave Read/Write Handshake Controller

This block sits between a bus master and a local device and sequences the handshake of every read and write cycle. The master signals a cycle with one of two strobes: one for reads and one for writes. The controller then drives a strobe to the local device, an enable for the data transceiver and latch, and an acknowledge back to the master. The order of these three outputs depends on the cycle type. In both cases the data is valid before the master is acknowledged.

On a read, the device is strobed first. Once the device acknowledges, the data path is opened and the master is acknowledged. On a write, the data path is opened before the device is strobed. Once the device acknowledges, the data path closes and the master is acknowledged. The release of the device strobe is decoupled from the release of the device acknowledge. A new cycle therefore waits until the device has dropped its acknowledge from the previous cycle. All inputs are assumed to be already synchronous to the clock. Every output change lands on the first clock edge at which its enabling input condition is seen.

Top module: `hs_slave_ctrl`

## Requirements
- R1: A synchronous active-high reset drives `dev_strobe_o`, `data_en_o`, `bus_ack_o` and `conflict_o` low on the next edge and returns the controller to idle, including from the middle of a cycle.
- R2: Read start: when the idle controller samples `rd_strobe_i` high, `wr_strobe_i` low and `dev_ack_i` low, `dev_strobe_o` rises on that edge. `data_en_o` and `bus_ack_o` stay low until the device acknowledges.
- R3: Read data: with `dev_strobe_o` high and the read in progress, the edge that samples `dev_ack_i` high raises `data_en_o`. `bus_ack_o` rises on the following edge.
- R4: Read release: the edge that samples `rd_strobe_i` low after the read acknowledge drops `data_en_o`. The next edge drops `bus_ack_o` and `dev_strobe_o` together.
- R5: Write start: when the idle controller samples `wr_strobe_i` high, `rd_strobe_i` low and `dev_ack_i` low, `data_en_o` rises on that edge. `dev_strobe_o` rises on the following edge.
- R6: Write acknowledge: the edge that samples `dev_ack_i` high during a write drops `data_en_o`. `bus_ack_o` rises on the following edge.
- R7: Write release: the edge that samples `wr_strobe_i` low after the write acknowledge drops `bus_ack_o` and `dev_strobe_o` together.
- R8: `dev_strobe_o` rises only on an edge that samples `dev_ack_i` low. A cycle requested while the device still holds its acknowledge from the previous cycle makes no output change until that acknowledge falls.
- R9: When both master strobes are sampled high, `conflict_o` is high after that edge and an idle controller starts no cycle. `conflict_o` is low after any edge that does not sample both strobes high.
- R10: The output vector {`bus_ack_o`, `dev_strobe_o`, `data_en_o`} steps through 010, 011, 111, 110, 000 on a read and 001, 011, 010, 110, 000 on a write. `bus_ack_o` rises only while `dev_strobe_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_strobe_i | input | 1 | Master read strobe |
| wr_strobe_i | input | 1 | Master write strobe |
| dev_ack_i | input | 1 | Acknowledge from the local device |
| dev_strobe_o | output | 1 | Strobe to the local device |
| data_en_o | output | 1 | Data transceiver / latch enable |
| bus_ack_o | output | 1 | Acknowledge to the master |
| conflict_o | output | 1 | Both master strobes seen high |

## Verification
Reads and writes are run back to back with random device response times and random master hold times. The bench tracks every output change and compares it with the expected order, so a read-style ordering on a write, or the reverse, is caught.

Some cycles start while the previous acknowledge is still held for a random number of cycles. These show whether the controller waits for that acknowledge to drop or strobes too early. A conflict pattern with both strobes high separates a correct refusal from a cycle that starts anyway. A reset in the middle of a read shows whether all outputs clear at once.

// File: rtl/hs_pkg.sv
package hs_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_R_STRB,
    ST_R_DATA,
    ST_R_ACK,
    ST_R_DROP,
    ST_W_SETUP,
    ST_W_STRB,
    ST_W_DROP,
    ST_W_ACK
  } hs_state_e;

  typedef struct packed {
    logic ack;
    logic strb;
    logic den;
  } hs_out_t;

  function automatic hs_out_t state_out(hs_state_e s);
    hs_out_t o;
    o = '0;
    case (s)
      ST_R_STRB:  o = '{ack: 1'b0, strb: 1'b1, den: 1'b0};
      ST_R_DATA:  o = '{ack: 1'b0, strb: 1'b1, den: 1'b1};
      ST_R_ACK:   o = '{ack: 1'b1, strb: 1'b1, den: 1'b1};
      ST_R_DROP:  o = '{ack: 1'b1, strb: 1'b1, den: 1'b0};
      ST_W_SETUP: o = '{ack: 1'b0, strb: 1'b0, den: 1'b1};
      ST_W_STRB:  o = '{ack: 1'b0, strb: 1'b1, den: 1'b1};
      ST_W_DROP:  o = '{ack: 1'b0, strb: 1'b1, den: 1'b0};
      ST_W_ACK:   o = '{ack: 1'b1, strb: 1'b1, den: 1'b0};
      default:    o = '0;
    endcase
    return o;
  endfunction
endpackage

// File: rtl/hs_strobe_decode.sv
module hs_strobe_decode (
  input  logic rd_i,
  input  logic wr_i,
  input  logic dev_ack_i,
  output logic start_rd_o,
  output logic start_wr_o,
  output logic clash_o
);
  always_comb begin
    clash_o    = rd_i & wr_i;
    start_rd_o = rd_i & ~wr_i & ~dev_ack_i;
    start_wr_o = wr_i & ~rd_i & ~dev_ack_i;
  end
endmodule

// File: rtl/hs_sequencer.sv
module hs_sequencer
  import hs_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    start_rd_i,
  input  logic    start_wr_i,
  input  logic    rd_i,
  input  logic    wr_i,
  input  logic    dev_ack_i,
  output hs_out_t out_o
);
  hs_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: begin
        if (start_rd_i)      state_d = ST_R_STRB;
        else if (start_wr_i) state_d = ST_W_SETUP;
      end
      ST_R_STRB:  if (dev_ack_i) state_d = ST_R_DATA;
      ST_R_DATA:  state_d = ST_R_ACK;
      ST_R_ACK:   if (!rd_i) state_d = ST_R_DROP;
      ST_R_DROP:  state_d = ST_IDLE;
      ST_W_SETUP: state_d = ST_W_STRB;
      ST_W_STRB:  if (dev_ack_i) state_d = ST_W_DROP;
      ST_W_DROP:  state_d = ST_W_ACK;
      ST_W_ACK:   if (!wr_i) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      out_o   <= '0;
    end else begin
      state_q <= state_d;
      out_o   <= state_out(state_d);
    end
  end
endmodule

// File: rtl/hs_slave_ctrl.sv
module hs_slave_ctrl
  import hs_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic rd_strobe_i,
  input  logic wr_strobe_i,
  input  logic dev_ack_i,
  output logic dev_strobe_o,
  output logic data_en_o,
  output logic bus_ack_o,
  output logic conflict_o
);
  logic    start_rd, start_wr, clash;
  hs_out_t outs;
  logic    conflict_q;

  hs_strobe_decode u_dec (
    .rd_i       (rd_strobe_i),
    .wr_i       (wr_strobe_i),
    .dev_ack_i  (dev_ack_i),
    .start_rd_o (start_rd),
    .start_wr_o (start_wr),
    .clash_o    (clash)
  );

  hs_sequencer u_seq (
    .clk        (clk),
    .rst        (rst),
    .start_rd_i (start_rd),
    .start_wr_i (start_wr),
    .rd_i       (rd_strobe_i),
    .wr_i       (wr_strobe_i),
    .dev_ack_i  (dev_ack_i),
    .out_o      (outs)
  );

  always_ff @(posedge clk) begin
    if (rst) conflict_q <= 1'b0;
    else     conflict_q <= clash;
  end

  assign dev_strobe_o = outs.strb;
  assign data_en_o    = outs.den;
  assign bus_ack_o    = outs.ack;
  assign conflict_o   = conflict_q;
endmodule

// File: rtl/hs_slave_ctrl_chk.sv
module hs_slave_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic rd_strobe_i,
  input logic wr_strobe_i,
  input logic dev_ack_i,
  input logic dev_strobe_o,
  input logic data_en_o,
  input logic bus_ack_o,
  input logic conflict_o
);
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!dev_strobe_o && !data_en_o && !bus_ack_o && !conflict_o)); // R1
  AST_READ_ACK_FOLLOWS_DATA: assert property (@(posedge clk) disable iff (rst)
    ($rose(data_en_o) && dev_strobe_o) |=> bus_ack_o); // R3
  AST_READ_RELEASE: assert property (@(posedge clk) disable iff (rst)
    ($fell(data_en_o) && bus_ack_o) |=> (!bus_ack_o && !dev_strobe_o)); // R4
  AST_WRITE_STROBE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    ($rose(data_en_o) && !dev_strobe_o) |=> dev_strobe_o); // R5
  AST_ACK_STROBE_RELEASE: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_ack_o) |-> !dev_strobe_o); // R7
  AST_STROBE_AFTER_ACK_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(dev_strobe_o) |-> $past(!dev_ack_i)); // R8
  AST_CONFLICT_FLAG: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe_i && wr_strobe_i) |=> conflict_o); // R9
  AST_CONFLICT_NO_START: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe_i && wr_strobe_i && !dev_strobe_o && !data_en_o && !bus_ack_o)
    |=> (!dev_strobe_o && !data_en_o)); // R9
  AST_ACK_UNDER_STROBE: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_ack_o) |-> dev_strobe_o); // R10
endmodule

bind hs_slave_ctrl hs_slave_ctrl_chk chk_i (
  .clk          (clk),
  .rst          (rst),
  .rd_strobe_i  (rd_strobe_i),
  .wr_strobe_i  (wr_strobe_i),
  .dev_ack_i    (dev_ack_i),
  .dev_strobe_o (dev_strobe_o),
  .data_en_o    (data_en_o),
  .bus_ack_o    (bus_ack_o),
  .conflict_o   (conflict_o)
);

// File: tb/hs_slave_ctrl_tb_top.sv
`timescale 1ns/1ps
module hs_slave_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rd = 1'b0, wr = 1'b0, dack = 1'b0;
  logic dstrb, den, back, confl;
  int   n_run = 0, n_fail = 0;
  logic [2:0] exp_q[$];
  logic [2:0] last_v = 3'b000;
  bit   finished = 1'b0;

  always #2.5 clk = ~clk;

  hs_slave_ctrl dut_i (
    .clk(clk), .rst(rst),
    .rd_strobe_i(rd), .wr_strobe_i(wr), .dev_ack_i(dack),
    .dev_strobe_o(dstrb), .data_en_o(den), .bus_ack_o(back), .conflict_o(confl)
  );

  task automatic check(input bit ok, input string req, input logic [3:0] act, input logic [3:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
    end
  endtask

  function automatic logic [3:0] vec();
    return {confl, back, dstrb, den};
  endfunction

  task automatic expect_v(input logic [3:0] e, input string req);
    check(vec() == e, req, vec(), e);
  endtask

  // scoreboard monitor: every output change must match the next queued step
  always @(posedge clk) begin
    #1;
    if (rst) begin
      exp_q.delete();
      last_v = {back, dstrb, den};
    end else if ({back, dstrb, den} != last_v) begin
      last_v = {back, dstrb, den};
      if (exp_q.size() == 0) check(1'b0, "R10 unexpected change", {1'b0, last_v}, 4'b0);
      else begin
        logic [2:0] e;
        e = exp_q.pop_front();
        check(last_v == e, "R10 order", {1'b0, last_v}, {1'b0, e});
      end
    end
  end

  task automatic do_read(input int lag, input int hold);
    exp_q.push_back(3'b010); exp_q.push_back(3'b011); exp_q.push_back(3'b111);
    exp_q.push_back(3'b110); exp_q.push_back(3'b000);
    @(negedge clk) rd = 1'b1;
    for (int k = 0; k < lag; k++) begin
      @(posedge clk); #1 expect_v(4'b0000, "R8 read waits ack low");
      @(negedge clk);
    end
    dack = 1'b0;
    @(posedge clk); #1 expect_v(4'b0010, "R2 read strobe");
    for (int k = 0; k < hold; k++) begin
      @(posedge clk); #1 expect_v(4'b0010, "R2 read holds");
    end
    @(negedge clk) dack = 1'b1;
    @(posedge clk); #1 expect_v(4'b0011, "R3 data enable");
    @(posedge clk); #1 expect_v(4'b0111, "R3 bus ack");
    for (int k = 0; k < hold; k++) begin
      @(posedge clk); #1 expect_v(4'b0111, "R3 held");
    end
    @(negedge clk) rd = 1'b0;
    @(posedge clk); #1 expect_v(4'b0110, "R4 data drop");
    @(posedge clk); #1 expect_v(4'b0000, "R4 release");
  endtask

  task automatic do_write(input int lag, input int hold);
    exp_q.push_back(3'b001); exp_q.push_back(3'b011); exp_q.push_back(3'b010);
    exp_q.push_back(3'b110); exp_q.push_back(3'b000);
    @(negedge clk) wr = 1'b1;
    for (int k = 0; k < lag; k++) begin
      @(posedge clk); #1 expect_v(4'b0000, "R8 write waits ack low");
      @(negedge clk);
    end
    dack = 1'b0;
    @(posedge clk); #1 expect_v(4'b0001, "R5 data first");
    @(posedge clk); #1 expect_v(4'b0011, "R5 strobe next");
    for (int k = 0; k < hold; k++) begin
      @(posedge clk); #1 expect_v(4'b0011, "R5 held");
    end
    @(negedge clk) dack = 1'b1;
    @(posedge clk); #1 expect_v(4'b0010, "R6 data drop");
    @(posedge clk); #1 expect_v(4'b0110, "R6 bus ack");
    for (int k = 0; k < hold; k++) begin
      @(posedge clk); #1 expect_v(4'b0110, "R6 held");
    end
    @(negedge clk) wr = 1'b0;
    @(posedge clk); #1 expect_v(4'b0000, "R7 release");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 expect_v(4'b0000, "R1 reset state");
    @(negedge clk) rst = 1'b0;
    @(posedge clk); #1 expect_v(4'b0000, "R1 idle after reset");
    do_read(0, 2);
    do_write(0, 1);
    for (int i = 0; i < 20; i++) begin
      if ($urandom_range(1, 0) == 1) do_read($urandom_range(4, 0), $urandom_range(5, 0));
      else do_write($urandom_range(4, 0), $urandom_range(5, 0));
    end
    do_read(3, 0);
    do_write(2, 0);
    // conflict
    @(negedge clk) begin dack = 1'b0; rd = 1'b1; wr = 1'b1; end
    repeat (3) begin @(posedge clk); #1 expect_v(4'b1000, "R9 conflict flag, no start"); end
    @(negedge clk) begin rd = 1'b0; wr = 1'b0; end
    @(posedge clk); #1 expect_v(4'b0000, "R9 flag clears");
    // reset mid-read
    exp_q.push_back(3'b010); exp_q.push_back(3'b011);
    @(negedge clk) rd = 1'b1;
    @(posedge clk); #1;
    @(negedge clk) dack = 1'b1;
    @(posedge clk); #1 expect_v(4'b0011, "R3 before reset");
    @(negedge clk) begin rst = 1'b1; rd = 1'b0; dack = 1'b0; end
    @(posedge clk); #1 expect_v(4'b0000, "R1 mid-cycle reset");
    @(negedge clk) rst = 1'b0;
    do_write(0, 1);
    repeat (2) @(posedge clk);
    #1 check(exp_q.size() == 0, "R10 all steps seen", exp_q.size(), 0);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule